// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Host Register File

This block is a countdown watchdog behind a small host register file. Software programs a period and starts the count. Each cycle in which `tick_en` is high moves the count down by one. If the count runs out once, the block reports a maskable event: an SMI pulse when `smi_en` is high, otherwise an NMI pulse. It then reloads from the period and keeps counting. If the count runs out a second time without a reload write in between, the block sets a boot flag and a second-timeout flag. It then asks for a system reset, unless a no-reboot control bit or the `no_reboot_strap` input blocks the reset. The register file also has a data-in byte that raises a software SMI, a data-out byte that raises an interrupt-status flag, two message bytes, a count byte and a software-interrupt byte.

Host access is a synchronous 16-bit write port with a byte address and a combinational read of the same address. Byte addresses:

| Register | Address |
|---|---|
| reload/count | 0x00 |
| data-in | 0x02 |
| data-out | 0x03 |
| status-A | 0x04 |
| status-B | 0x06 |
| control-A | 0x08 |
| control-B | 0x0A |
| message bytes | 0x0C, 0x0D |
| count byte | 0x0E |
| period | 0x12 |
| software-interrupt byte | 0x14 |

The period register keeps only its low 10 bits.

Top module: `wdt2_top`

## Requirements
- R1: After reset, period reads 4, control-B reads 0x0008 and the software-interrupt byte reads 0x0003. Every other register reads 0, the timer is stopped and all outputs are low.
- R2: The count runs only when the halt bit (control-A bit 11) is clear and the period is greater than 1. A period of 0 or 1, or a set halt bit, never starts the count, and a stopped count does not change on ticks.
- R3: A running count drops by one on each tick-enable cycle. Reading the reload register shows the ticks left.
- R4: An expiry occurs on a tick that finds a count of 1 or less. On the first expiry, status-A bit 3 is set and a one-cycle SMI pulse is produced if `smi_en` is high, otherwise a one-cycle NMI pulse. The count then reloads from the period.
- R5: On the second consecutive expiry, status-B bits 1 and 2 are set. If both control-A bit 9 and `no_reboot_strap` are low, `rst_req_o` pulses for one cycle, the count stops and the reload register reads 0.
- R6: A second expiry that is blocked (control-A bit 9 or the strap set) behaves like a first expiry: an SMI or NMI pulse and a reload. The status-B bits are still set.
- R7: Any write to the reload register clears the expiry tally. If the count may run, it restarts from the period. Otherwise the written value is stored as the count.
- R8: A control-A write keeps only bits 9, 11 and 12. Bit 12 (lock), once set, stays set until reset. After the write, the count restarts from the period if it may run, otherwise it stops.
- R9: A data-in write sets status-A bit 1 and pulses SMI for one cycle. A data-out write sets status-A bit 2, which drives `irq_sts_o`.
- R10: Host writes to the status words store the written value masked: 0x000E for status-A and 0x0006 for status-B.
- R11: Unmapped addresses read 0 and ignore writes. A tick in the same cycle as any host write is dropped.
- R12: While running after a reload write that stored a value, the reload register reads the stored upper 6 bits with the live count in bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 5 | Host byte address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data for `addr` |
| tick_en | input | 1 | Count-down enable, one tick per cycle |
| smi_en | input | 1 | Route expiry events to SMI instead of NMI |
| no_reboot_strap | input | 1 | Blocks the reset request when high |
| smi_o | output | 1 | One-cycle SMI pulse |
| nmi_o | output | 1 | One-cycle NMI pulse |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_sts_o | output | 1 | Interrupt-status flag (status-A bit 2) |

## Verification
A wrong expiry tally appears as a reset pulse one expiry too early or too late. The bench catches this by counting ticks across two full periods and checking the three event outputs on every tick. A stale count appears on the reload register after a single tick, so count reads follow individual ticks. Lost lock or flag bits appear on the very next read of the control or status word, and all event pulses are checked in the cycle right after the edge that caused them.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] A_DIN    = 5'h02;
  localparam logic [ADDR_W-1:0] A_DOUT   = 5'h03;
  localparam logic [ADDR_W-1:0] A_STATA  = 5'h04;
  localparam logic [ADDR_W-1:0] A_STATB  = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTRLA  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTRLB  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_MSG0   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_WDCNT  = 5'h0E;
  localparam logic [ADDR_W-1:0] A_PERIOD = 5'h12;
  localparam logic [ADDR_W-1:0] A_SWIRQ  = 5'h14;

  localparam int SA_SWSMI   = 1;
  localparam int SA_INT     = 2;
  localparam int SA_TIMEOUT = 3;
  localparam int SB_SECOND  = 1;
  localparam int SB_BOOT    = 2;
  localparam int CA_NOREBOOT = 9;
  localparam int CA_HALT     = 11;
  localparam int CA_LOCK     = 12;

  localparam logic [15:0] STATA_MASK = 16'h000E;
  localparam logic [15:0] STATB_MASK = 16'h0006;
  localparam logic [15:0] CTRLA_MASK = 16'h1A00;

  typedef struct packed {
    logic expire;
    logic second;
    logic fire_rst;
    logic smi;
    logic nmi;
  } wdt2_evt_t;

  function automatic logic may_count(input logic halt, input logic [15:0] period);
    return !halt && (period > 16'd1);
  endfunction
endpackage

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
  import wdt2_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             any_wr,
  input  logic             wr_reload,
  input  logic             wr_ctrl,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] period,
  input  logic             halt_cur,
  input  logic             no_reboot,
  input  logic             strap,
  input  logic             smi_en,
  output logic [DW-1:0]    rld_q,
  output logic             running_q,
  output wdt2_evt_t        evt
);
  localparam int PAD_W = DW - CNT_W;

  logic             tally_q;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    period_ext;
  logic             run_ok_cur;
  logic             run_ok_new;
  logic             tick_go;

  assign cnt        = rld_q[CNT_W-1:0];
  assign period_ext = {{PAD_W{1'b0}}, period};
  assign run_ok_cur = may_count(halt_cur, period_ext);
  assign run_ok_new = may_count(wdata[CA_HALT], period_ext);
  assign tick_go    = running_q && tick_en && !any_wr;

  always_comb begin
    evt.expire   = tick_go && (cnt <= CNT_W'(1));
    evt.second   = evt.expire && tally_q;
    evt.fire_rst = evt.second && !no_reboot && !strap;
    evt.smi      = evt.expire && !evt.fire_rst && smi_en;
    evt.nmi      = evt.expire && !evt.fire_rst && !smi_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q     <= '0;
      running_q <= 1'b0;
      tally_q   <= 1'b0;
    end else if (wr_reload) begin
      tally_q <= 1'b0;
      if (run_ok_cur) begin
        rld_q     <= period_ext;
        running_q <= 1'b1;
      end else begin
        rld_q <= wdata;
      end
    end else if (wr_ctrl) begin
      if (run_ok_new) begin
        rld_q     <= period_ext;
        running_q <= 1'b1;
      end else begin
        running_q <= 1'b0;
      end
    end else if (evt.expire) begin
      tally_q <= !tally_q;
      if (evt.fire_rst) begin
        rld_q     <= '0;
        running_q <= 1'b0;
      end else begin
        rld_q <= period_ext;
      end
    end else if (tick_go) begin
      rld_q[CNT_W-1:0] <= cnt - CNT_W'(1);
    end
  end

  p_rst_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fire_rst |=> (!running_q && rld_q == '0));

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && cnt > CNT_W'(1)) |=> (rld_q[CNT_W-1:0] == $past(cnt) - CNT_W'(1)));

  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $rose(running_q)) |-> ($past(wr_reload || wr_ctrl) && $past(period) > CNT_W'(1)));
endmodule

// File: rtl/wdt2_regfile.sv
module wdt2_regfile
  import wdt2_pkg::*;
#(
  parameter int DW     = 16,
  parameter int BW     = 8,
  parameter int CNT_W  = 10,
  parameter int N_MSG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     rld_q,
  input  wdt2_evt_t         evt,
  output logic [DW-1:0]     rdata,
  output logic [CNT_W-1:0]  period_q,
  output logic [DW-1:0]     ctrla_q,
  output logic              din_wr,
  output logic              irq_sts
);
  localparam int PAD_B = DW - BW;
  localparam int PAD_C = DW - CNT_W;

  logic [BW-1:0] din_q, dout_q, wdcnt_q, swirq_q;
  logic [DW-1:0] stata_q, statb_q, ctrlb_q;
  logic [BW-1:0] msg_q [N_MSG];

  assign din_wr  = wr_en && (addr == A_DIN);
  assign irq_sts = stata_q[SA_INT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q    <= '0;
      dout_q   <= '0;
      wdcnt_q  <= '0;
      swirq_q  <= BW'(8'h03);
      ctrlb_q  <= DW'(16'h0008);
      ctrla_q  <= '0;
      period_q <= CNT_W'(4);
    end else if (wr_en) begin
      case (addr)
        A_DIN:    din_q    <= wdata[BW-1:0];
        A_DOUT:   dout_q   <= wdata[BW-1:0];
        A_WDCNT:  wdcnt_q  <= wdata[BW-1:0];
        A_SWIRQ:  swirq_q  <= wdata[BW-1:0];
        A_CTRLB:  ctrlb_q  <= wdata;
        A_CTRLA:  ctrla_q  <= (wdata & CTRLA_MASK) | (ctrla_q & (DW'(1) << CA_LOCK));
        A_PERIOD: period_q <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_MSG; g++) begin : g_msg
    always_ff @(posedge clk) begin
      if (!rst_n) msg_q[g] <= '0;
      else if (wr_en && addr == A_MSG0 + ADDR_W'(g)) msg_q[g] <= wdata[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stata_q <= '0;
    end else if (wr_en && addr == A_STATA) begin
      stata_q <= wdata & STATA_MASK;
    end else begin
      if (evt.expire)                   stata_q[SA_TIMEOUT] <= 1'b1;
      if (din_wr)                       stata_q[SA_SWSMI]   <= 1'b1;
      if (wr_en && addr == A_DOUT)      stata_q[SA_INT]     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statb_q <= '0;
    end else if (wr_en && addr == A_STATB) begin
      statb_q <= wdata & STATB_MASK;
    end else if (evt.second) begin
      statb_q[SB_SECOND] <= 1'b1;
      statb_q[SB_BOOT]   <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RELOAD: rdata = rld_q;
      A_DIN:    rdata = {{PAD_B{1'b0}}, din_q};
      A_DOUT:   rdata = {{PAD_B{1'b0}}, dout_q};
      A_STATA:  rdata = stata_q;
      A_STATB:  rdata = statb_q;
      A_CTRLA:  rdata = ctrla_q;
      A_CTRLB:  rdata = ctrlb_q;
      A_WDCNT:  rdata = {{PAD_B{1'b0}}, wdcnt_q};
      A_PERIOD: rdata = {{PAD_C{1'b0}}, period_q};
      A_SWIRQ:  rdata = {{PAD_B{1'b0}}, swirq_q};
      default: begin
        for (int m = 0; m < N_MSG; m++)
          if (addr == A_MSG0 + ADDR_W'(m)) rdata = {{PAD_B{1'b0}}, msg_q[m]};
      end
    endcase
  end

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrla_q[CA_LOCK] |=> ctrla_q[CA_LOCK]);

  p_second_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.second |=> (statb_q[SB_SECOND] && statb_q[SB_BOOT]));

  p_timeout_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.expire |=> stata_q[SA_TIMEOUT]);
endmodule

// File: rtl/wdt2_pulse_reg.sv
module wdt2_pulse_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              tick_en,
  input  logic              smi_en,
  input  logic              no_reboot_strap,
  output logic              smi_o,
  output logic              nmi_o,
  output logic              rst_req_o,
  output logic              irq_sts_o
);
  wdt2_evt_t        evt;
  logic [DW-1:0]    rld_q;
  logic             running_q;
  logic [CNT_W-1:0] period_q;
  logic [DW-1:0]    ctrla_q;
  logic             din_wr;
  logic [2:0]       pulse_d, pulse_q;

  wdt2_regfile #(.DW(DW), .BW(8), .CNT_W(CNT_W), .N_MSG(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rld_q(rld_q), .evt(evt), .rdata(rdata), .period_q(period_q),
    .ctrla_q(ctrla_q), .din_wr(din_wr), .irq_sts(irq_sts_o)
  );

  wdt2_countdown #(.DW(DW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .any_wr(wr_en),
    .wr_reload(wr_en && addr == A_RELOAD), .wr_ctrl(wr_en && addr == A_CTRLA),
    .wdata(wdata), .period(period_q), .halt_cur(ctrla_q[CA_HALT]),
    .no_reboot(ctrla_q[CA_NOREBOOT]), .strap(no_reboot_strap), .smi_en(smi_en),
    .rld_q(rld_q), .running_q(running_q), .evt(evt)
  );

  assign pulse_d = {evt.smi || din_wr, evt.nmi, evt.fire_rst};

  wdt2_pulse_reg #(.N(3)) u_pulse (
    .clk(clk), .rst_n(rst_n), .d(pulse_d), .q(pulse_q)
  );

  assign smi_o     = pulse_q[2];
  assign nmi_o     = pulse_q[1];
  assign rst_req_o = pulse_q[0];

  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_smi_nmi_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_o && nmi_o));

  p_rst_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !running_q);
endmodule

// File: tb/wdt2_top_test.sv
module wdt2_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick_en = 1'b0;
  logic        smi_en = 1'b0;
  logic        no_reboot_strap = 1'b0;
  logic        smi_o, nmi_o, rst_req_o, irq_sts_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_en(tick_en), .smi_en(smi_en),
    .no_reboot_strap(no_reboot_strap), .smi_o(smi_o), .nmi_o(nmi_o),
    .rst_req_o(rst_req_o), .irq_sts_o(irq_sts_o)
  );

  // op: 0 write, 1 read+compare, 2 one tick then compare outputs, 3 compare outputs
  // outputs compared as {smi, nmi, rst_req, irq_sts}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 5'h08, 16'h0000, 16'h0000}, // R8 start count from period 4
    {2'd1, 5'h00, 16'h0000, 16'h0004}, // R7 count loaded from period
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3 tick, count 3
    {2'd1, 5'h00, 16'h0000, 16'h0003}, // R3 ticks left
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3 count 1
    {2'd2, 5'h00, 16'h0000, 16'h0004}, // R4 first expiry -> NMI
    {2'd1, 5'h04, 16'h0000, 16'h0008}, // R4 timeout flag
    {2'd1, 5'h00, 16'h0000, 16'h0004}, // R4 reloaded
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R3
    {2'd2, 5'h00, 16'h0000, 16'h0002}, // R5 second expiry -> reset request
    {2'd1, 5'h06, 16'h0000, 16'h0006}, // R5 status-B flags
    {2'd1, 5'h00, 16'h0000, 16'h0000}, // R5 count cleared
    {2'd2, 5'h00, 16'h0000, 16'h0000}, // R5 stopped, no events
    {2'd1, 5'h00, 16'h0000, 16'h0000}, // R5 stays stopped
    {2'd0, 5'h03, 16'h0055, 16'h0000}, // R9 data-out write
    {2'd3, 5'h00, 16'h0000, 16'h0001}, // R9 irq_sts_o high
    {2'd1, 5'h04, 16'h0000, 16'h000C}, // R9 status-A bit 2
    {2'd0, 5'h04, 16'hFFFF, 16'h0000}, // R10 status-A write
    {2'd1, 5'h04, 16'h0000, 16'h000E}, // R10 masked
    {2'd0, 5'h04, 16'h0000, 16'h0000}, // R10 clear status-A
    {2'd1, 5'h1F, 16'h0000, 16'h0000}, // R11 unmapped reads 0
    {2'd0, 5'h10, 16'hFFFF, 16'h0000}, // R11 unmapped write
    {2'd1, 5'h10, 16'h0000, 16'h0000}  // R11 still 0
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [15:0] outs();
    return {12'd0, smi_o, nmi_o, rst_req_o, irq_sts_o};
  endfunction

  task automatic rchk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks_chk(input string req, input int n, input logic [15:0] exp_last);
    for (int i = 0; i < n; i++) begin
      tick1();
      chk(req, outs(), (i == n-1) ? exp_last : 16'h0000);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs", outs(), 16'h0000);
    rchk("R1 reload", 5'h00, 16'h0000);
    rchk("R1 din", 5'h02, 16'h0000);
    rchk("R1 dout", 5'h03, 16'h0000);
    rchk("R1 statA", 5'h04, 16'h0000);
    rchk("R1 statB", 5'h06, 16'h0000);
    rchk("R1 ctrlA", 5'h08, 16'h0000);
    rchk("R1 ctrlB", 5'h0A, 16'h0008);
    rchk("R1 msg0", 5'h0C, 16'h0000);
    rchk("R1 msg1", 5'h0D, 16'h0000);
    rchk("R1 wdcnt", 5'h0E, 16'h0000);
    rchk("R1 period", 5'h12, 16'h0004);
    rchk("R1 swirq", 5'h14, 16'h0003);
    tick1();
    rchk("R1 stopped after reset", 5'h00, 16'h0000);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [15:0] d, e, got;
      {op, a, d, e} = VEC[v];
      case (op)
        2'd0: wr(a, d);
        2'd1: begin rd(a, got); chk($sformatf("table row %0d", v), got, e); end
        2'd2: begin tick1(); chk($sformatf("table row %0d outputs", v), outs(), e); end
        default: chk($sformatf("table row %0d outputs", v), outs(), e);
      endcase
    end

    // R9 data-in write
    wr(5'h02, 16'h005A);
    chk("R9 smi pulse", outs(), 16'h0008);
    rchk("R9 statA swsmi", 5'h04, 16'h0002);
    rchk("R9 din value", 5'h02, 16'h005A);

    // R2 period gate, R7 stored value
    wr(5'h12, 16'h0001);
    wr(5'h08, 16'h0000);
    wr(5'h00, 16'h0123);
    tick1(); tick1(); tick1();
    rchk("R2 period 1 does not run", 5'h00, 16'h0123);
    rchk("R7 stored when not runnable", 5'h00, 16'h0123);
    wr(5'h12, 16'h0005);
    wr(5'h08, 16'h0800);
    tick1();
    rchk("R2 halt keeps stopped", 5'h00, 16'h0123);

    // R8 mask and lock
    wr(5'h08, 16'hFFFF);
    rchk("R8 ctrlA masked", 5'h08, 16'h1A00);
    wr(5'h08, 16'h0000);
    rchk("R8 lock sticky", 5'h08, 16'h1000);
    rchk("R8 restart from period", 5'h00, 16'h0005);

    // R7 reload write clears expiry tally
    wr(5'h06, 16'h0000);
    ticks_chk("R4 first expiry nmi", 5, 16'h0004);
    wr(5'h00, 16'h0000);
    rchk("R7 restart on reload write", 5'h00, 16'h0005);
    ticks_chk("R7 tally cleared, first again", 5, 16'h0004);
    rchk("R7 statB untouched", 5'h06, 16'h0000);

    // R6 blocked by strap, SMI route
    no_reboot_strap = 1'b1; smi_en = 1'b1;
    ticks_chk("R6 strap blocks reset", 5, 16'h0008);
    rchk("R6 statB flags", 5'h06, 16'h0006);
    rchk("R6 reloaded", 5'h00, 16'h0005);

    // R6 blocked by control bit
    no_reboot_strap = 1'b0;
    wr(5'h08, 16'h0200);
    rchk("R6 ctrlA", 5'h08, 16'h1200);
    ticks_chk("R6 ctrl first", 5, 16'h0008);
    ticks_chk("R6 ctrl blocks reset", 5, 16'h0008);

    // R11 tick dropped during host write
    rchk("R11 count before", 5'h00, 16'h0005);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 5'h0C; wdata = 16'h0077;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rchk("R11 tick dropped", 5'h00, 16'h0005);
    rchk("R11 msg written", 5'h0C, 16'h0077);

    // R12 stored upper bits with live count
    wr(5'h12, 16'h0000);
    wr(5'h00, 16'hFC02);
    tick1();
    rchk("R12 live count with upper bits", 5'h00, 16'hFC01);

    done = 1;
    summary();
    $finish;
  end
endmodule